// File: doc/BRIEF.md
# Flash Bus Cycle Decoder

This block watches the three active-low strobes of a parallel flash interface: chip enable, output enable and write enable. The strobes arrive with no relation to the system clock, so the block samples them with a faster clock. It sorts every bus state into one of six classes: standby, read, write, output-disable, illegal, or deselected while the program/erase engine is busy. It turns on the data-bus output driver only for a legal read. For each legal write it returns the address and the data as one pair, marked by a single-cycle valid pulse.

The write address is taken at the moment the write condition begins, which is whichever of chip enable or write enable falls last. The write data is taken when the write condition ends, which is whichever of the two rises first. An inactivity timer raises an automatic low-power flag when neither the strobes nor the address have changed for a set time. While that flag is up, the output driver keeps its state.

The strobes, the address and the data all pass through one matched two-stage sampling pipeline, so all of them are seen in the same clock. Each class flag is registered after the pipeline. A strobe change at the pins therefore shows on the class outputs three clock edges later.

Top module: `flash_strobe_decoder`

## Requirements
- R1: During reset, `dout_en`, `wr_valid` and `illegal` are 0, `standby` is 1 and `cyc_class` is 0 (standby).
- R2: With chip enable low, output enable low and write enable high, `dout_en` is 1 and `cyc_class` is 1 (read), three clock edges after the strobes settle.
- R3: With chip enable low and both output enable and write enable high, `dout_en` is 0 and `cyc_class` is 3 (output-disable).
- R4: With chip enable high and `eng_busy` low, `standby` is 1, `cyc_class` is 0 and `dout_en` is 0, whatever output enable and write enable are doing.
- R5: With chip enable high and `eng_busy` high, `standby` is 0, `cyc_class` is 5 (deselected-busy) and `dout_en` is 0.
- R6: With chip enable and write enable low and output enable high, `cyc_class` is 2 (write). The address reported for that write is the one present when the later of the two strobes fell.
- R7: When the first of chip enable or write enable rises and ends a legal write, `wr_valid` is high for exactly one clock. `wr_data` then holds the data present at that rise, and `wr_addr` holds the address from R6.
- R8: Output enable low together with chip enable and write enable low is illegal. `illegal` is 1, `cyc_class` is 4, `dout_en` is 0, and the write gives no `wr_valid` pulse and no change of `wr_addr` or `wr_data`.
- R9: `auto_stby` rises when neither the strobes nor the address have changed for IDLE_CYC clocks. IDLE_CYC is IDLE_NS rounded up to whole clock periods. It does not affect `dout_en`.
- R10: Any change of the address or of any strobe clears `auto_stby` and starts the count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable strobe, active low, asynchronous |
| we_n | input | 1 | Write enable strobe, active low, asynchronous |
| eng_busy | input | 1 | Program/erase engine is running |
| addr | input | AW | Flash address bus |
| din | input | DW | Flash data bus, write direction |
| wr_addr | output | AW | Address of the last legal write |
| wr_data | output | DW | Data of the last legal write |
| wr_valid | output | 1 | One-clock pulse when a write pair is published |
| dout_en | output | 1 | Drive enable for the read data bus |
| cyc_class | output | 3 | Current bus class: 0 standby, 1 read, 2 write, 3 output-disable, 4 illegal, 5 deselected-busy |
| illegal | output | 1 | Output enable and write enable low together under chip enable |
| standby | output | 1 | Chip deselected with the engine idle |
| auto_stby | output | 1 | Inactivity timeout reached |

## Verification
The bench builds the block with a 12-bit address, an 8-bit data bus, an 8000 ps clock period and IDLE_NS of 80. These values give a ten-cycle inactivity limit. With that limit the exact edge on which `auto_stby` rises can be checked, and it can also be shown to hold while a read keeps the driver on. The short buses let random writes cover all four orders of the strobe falls and rises, and they make a wrong address or data capture show up as a visible mismatch.

// File: rtl/flash_strobe_decoder.sv
`timescale 1ns/1ps
module flash_strobe_decoder #(
  parameter int AW            = 16,
  parameter int DW            = 8,
  parameter int CLK_PERIOD_PS = 8000,
  parameter int IDLE_NS       = 150
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          eng_busy,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_valid,
  output logic          dout_en,
  output logic [2:0]    cyc_class,
  output logic          illegal,
  output logic          standby,
  output logic          auto_stby
);

  localparam int IDLE_RAW = (IDLE_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int IDLE_CYC = (IDLE_RAW < 1) ? 1 : IDLE_RAW;
  localparam int CW       = $clog2(IDLE_CYC + 1);

  localparam logic [2:0] C_STBY  = 3'd0;
  localparam logic [2:0] C_READ  = 3'd1;
  localparam logic [2:0] C_WRITE = 3'd2;
  localparam logic [2:0] C_ODIS  = 3'd3;
  localparam logic [2:0] C_ILL   = 3'd4;
  localparam logic [2:0] C_DESEL = 3'd5;

  // strobe vector order: {ce, oe, we}, all active low
  logic [2:0]    st1, st2, stp;
  logic [AW-1:0] a1, a2, ap;
  logic [DW-1:0] d1, d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1 <= 3'b111;
      st2 <= 3'b111;
      stp <= 3'b111;
      a1  <= '0;
      a2  <= '0;
      ap  <= '0;
      d1  <= '0;
      d2  <= '0;
    end else begin
      st1 <= {ce_n, oe_n, we_n};
      st2 <= st1;
      stp <= st2;
      a1  <= addr;
      a2  <= a1;
      ap  <= a2;
      d1  <= din;
      d2  <= d1;
    end
  end

  wire ce_l = ~st2[2];
  wire oe_l = ~st2[1];
  wire we_l = ~st2[0];

  wire wr_lvl   = ce_l & we_l;
  wire wr_lvl_p = ~stp[2] & ~stp[0];
  wire wr_start = wr_lvl & ~wr_lvl_p;
  wire wr_end   = ~wr_lvl & wr_lvl_p;
  wire ill_now  = wr_lvl & oe_l;

  logic [2:0] cls;
  always_comb begin
    if (!ce_l)            cls = eng_busy ? C_DESEL : C_STBY;
    else if (we_l && oe_l) cls = C_ILL;
    else if (we_l)        cls = C_WRITE;
    else if (oe_l)        cls = C_READ;
    else                  cls = C_ODIS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_class <= C_STBY;
      dout_en   <= 1'b0;
      illegal   <= 1'b0;
      standby   <= 1'b1;
    end else begin
      cyc_class <= cls;
      dout_en   <= (cls == C_READ);
      illegal   <= (cls == C_ILL);
      standby   <= (cls == C_STBY);
    end
  end

  logic          open_q;
  logic [AW-1:0] pend_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      pend_addr <= '0;
    end else if (wr_start) begin
      open_q    <= ~oe_l;
      pend_addr <= a2;
    end else if (ill_now || wr_end) begin
      open_q    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= wr_end & open_q;
      if (wr_end && open_q) begin
        wr_addr <= pend_addr;
        wr_data <= d2;
      end
    end
  end

  wire activity = (st2 != stp) || (a2 != ap);
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         idle_cnt <= '0;
    else if (activity)                  idle_cnt <= '0;
    else if (idle_cnt != CW'(IDLE_CYC)) idle_cnt <= idle_cnt + 1'b1;
  end

  assign auto_stby = (idle_cnt == CW'(IDLE_CYC));

endmodule

// File: rtl/flash_strobe_decoder_chk.sv
`timescale 1ns/1ps
module flash_strobe_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       wr_valid,
  input logic       dout_en,
  input logic       illegal,
  input logic       auto_stby,
  input logic [2:0] cyc_class
);

  assert_read_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!$past(ce_n, 3) && !$past(oe_n, 3) && $past(we_n, 3)));

  assert_pulse_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  assert_end_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ($past(ce_n, 3) || $past(we_n, 3)));

  assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!dout_en && !wr_valid));

  assert_auto_keeps_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(auto_stby) |-> ($stable(dout_en) && $stable(cyc_class)));

  assert_edge_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !auto_stby);

endmodule

bind flash_strobe_decoder flash_strobe_decoder_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .wr_valid(wr_valid), .dout_en(dout_en), .illegal(illegal),
  .auto_stby(auto_stby), .cyc_class(cyc_class)
);

// File: tb/test_flash_strobe_decoder.sv
`timescale 1ns/1ps
module test_flash_strobe_decoder;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int BIDLE = (80 * 1000 + 7999) / 8000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, eng_busy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic wr_valid, dout_en, illegal, standby, auto_stby;
  logic [2:0] cyc_class;

  int errors = 0, checks = 0, pulses = 0;
  logic [AW-1:0] last_a = '0;
  logic [DW-1:0] last_d = '0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_strobe_decoder #(.AW(AW), .DW(DW), .CLK_PERIOD_PS(8000), .IDLE_NS(80)) i_flash_strobe_decoder (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .eng_busy(eng_busy),
    .addr(addr), .din(din), .wr_addr(wr_addr), .wr_data(wr_data), .wr_valid(wr_valid),
    .dout_en(dout_en), .cyc_class(cyc_class), .illegal(illegal), .standby(standby),
    .auto_stby(auto_stby));

  always @(negedge clk) if (rst_n && wr_valid) begin
    pulses++;
    last_a = wr_addr;
    last_d = wr_data;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_cls(input logic c, input logic o, input logic w, input logic b);
    if (c) return b ? 3'd5 : 3'd0;
    if (!w && !o) return 3'd4;
    if (!w) return 3'd2;
    if (!o) return 3'd1;
    return 3'd3;
  endfunction

  task automatic strobes(input logic c, input logic o, input logic w, input logic b, input string req);
    ce_n = c; oe_n = o; we_n = w; eng_busy = b;
    cyc(4);
    chk({req, " class"}, {29'd0, cyc_class}, {29'd0, exp_cls(c, o, w, b)});
    chk({req, " dout_en"}, {31'd0, dout_en}, {31'd0, (exp_cls(c, o, w, b) == 3'd1)});
    chk({req, " standby"}, {31'd0, standby}, {31'd0, (exp_cls(c, o, w, b) == 3'd0)});
  endtask

  task automatic do_write(input bit ce_fall_first, input bit ce_rise_first,
                          input logic [AW-1:0] a, input logic [DW-1:0] d);
    int p0;
    p0 = pulses;
    ce_n = 1; we_n = 1; oe_n = 1; eng_busy = 0; addr = ~a; din = ~d;
    cyc(2);
    if (ce_fall_first) ce_n = 0; else we_n = 0;
    cyc(3);
    addr = a;
    if (ce_fall_first) we_n = 0; else ce_n = 0;
    cyc(3);
    chk("R6 write class", {29'd0, cyc_class}, 32'd2);
    addr = ~a; din = d;
    cyc(3);
    if (ce_rise_first) ce_n = 1; else we_n = 1;
    cyc(3);
    din = ~d;
    ce_n = 1; we_n = 1;
    cyc(4);
    chk("R7 one pulse", pulses - p0, 32'd1);
    chk("R6 address", {20'd0, last_a}, {20'd0, a});
    chk("R7 data", {24'd0, last_d}, {24'd0, d});
  endtask

  initial begin
    void'($urandom(32'd7531));
    cyc(3);
    chk("R1 reset dout_en", {31'd0, dout_en}, 32'd0);
    chk("R1 reset wr_valid", {31'd0, wr_valid}, 32'd0);
    chk("R1 reset illegal", {31'd0, illegal}, 32'd0);
    chk("R1 reset standby", {31'd0, standby}, 32'd1);
    chk("R1 reset class", {29'd0, cyc_class}, 32'd0);
    rst_n = 1'b1;

    strobes(1, 1, 1, 0, "R4");
    strobes(1, 0, 0, 0, "R4");
    strobes(1, 0, 1, 0, "R4");
    strobes(1, 1, 1, 1, "R5");
    strobes(1, 0, 1, 1, "R5");
    strobes(0, 0, 1, 0, "R2");
    strobes(0, 1, 1, 0, "R3");
    strobes(1, 1, 1, 0, "R4");

    do_write(1, 1, 12'h3A5, 8'h5C);
    do_write(1, 0, 12'h0F1, 8'hA3);
    do_write(0, 1, 12'hC42, 8'h19);
    do_write(0, 0, 12'h7BE, 8'hE6);

    // illegal: output enable drops during an open write
    begin
      int p0;
      logic [AW-1:0] a0;
      p0 = pulses; a0 = wr_addr;
      addr = 12'h555; din = 8'h77;
      ce_n = 0; cyc(2); we_n = 0; cyc(4);
      oe_n = 0; cyc(4);
      chk("R8 illegal flag", {31'd0, illegal}, 32'd1);
      chk("R8 class", {29'd0, cyc_class}, 32'd4);
      chk("R8 no drive", {31'd0, dout_en}, 32'd0);
      oe_n = 1; cyc(3); we_n = 1; ce_n = 1; cyc(5);
      chk("R8 no pulse", pulses - p0, 32'd0);
      chk("R8 address kept", {20'd0, wr_addr}, {20'd0, a0});
      // illegal from the start
      ce_n = 0; oe_n = 0; cyc(2); we_n = 0; cyc(4);
      chk("R8 illegal start", {31'd0, illegal}, 32'd1);
      we_n = 1; ce_n = 1; oe_n = 1; cyc(5);
      chk("R8 no pulse start", pulses - p0, 32'd0);
    end

    // inactivity timer during a read
    ce_n = 0; oe_n = 0; we_n = 1; cyc(20);
    addr = 12'h111;
    cyc(BIDLE + 2);
    chk("R9 not yet", {31'd0, auto_stby}, 32'd0);
    cyc(1);
    chk("R9 auto up", {31'd0, auto_stby}, 32'd1);
    chk("R9 still driving", {31'd0, dout_en}, 32'd1);
    addr = 12'h112; cyc(3);
    chk("R10 addr clears", {31'd0, auto_stby}, 32'd0);
    cyc(BIDLE + 4);
    chk("R9 auto again", {31'd0, auto_stby}, 32'd1);
    oe_n = 1; cyc(3);
    chk("R10 strobe clears", {31'd0, auto_stby}, 32'd0);
    ce_n = 1; cyc(4);

    for (int i = 0; i < 60; i++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: strobes(0, 0, 1, 0, "R2 rnd");
        1: strobes(0, 1, 1, $urandom_range(0, 1), "R3 rnd");
        2: strobes(1, $urandom_range(0, 1), $urandom_range(0, 1), 0, "R4 rnd");
        3: strobes(1, $urandom_range(0, 1), $urandom_range(0, 1), 1, "R5 rnd");
        default: do_write($urandom_range(0, 1), $urandom_range(0, 1),
                          AW'($urandom), DW'($urandom));
      endcase
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule